// File: doc/BRIEF.md
# Microcode Sequencer Branch and Call Unit

This block is the flow-control half of a sequencer that runs 32-bit microinstructions. It holds a 9-bit program counter and presents it as the fetch address. It decodes the opcode in each instruction it accepts and picks the next address. That address may be the next sequential word, a branch target taken from the instruction, or an entry popped from a four-deep return stack. The ALU, the register file and the instruction memory all sit outside the block. The block tells the register file whether the current instruction writes a register and whether the write goes to the fixed index register or to the decoded destination.

Instructions arrive on a valid/ready stream. The instruction word must match the word stored at `fetch_addr`. A transfer happens on a rising edge where `instr_valid` and `instr_ready` are both high. While `instr_valid` is low, the program counter and all state hold, and no register write is requested. `instr_ready` stays high until an illegal instruction is accepted. From then on it stays low until reset, which is the only way to leave the halted state. The carry flag and the value read from the source register come in as plain inputs. They are sampled in the transfer cycle.

Top module: `seq_branch_unit`

## Requirements
- R1: After reset, `fetch_addr` is 0, `instr_ready` is 1, `illegal`, `stk_overflow` and `stk_underflow` are 0, and the return stack is empty.
- R2: An accepted instruction with opcode (bits 28..25) 0000 to 0101 and bit 24 clear is an ALU operation. It asserts `dst_we` in that cycle, with `dst_to_index` 0 and `dst_addr` equal to bits 23..16. The next fetch address is the current one plus 1, wrapping from 511 to 0.
- R3: An accepted instruction with opcode 1000 to 1011 asserts `dst_we` with `dst_to_index` 1 and `dst_addr` 0 exactly when the source field (bits 15..8) or the immediate (bits 7..0) is nonzero. When no write is requested, `dst_to_index` and `dst_addr` are 0.
- R4: Opcode 1000 always branches to bits 24..16. Opcode 1001 branches only when `carry_in` is 1, and opcode 1010 branches only when `carry_in` is 0. A branch that is not taken goes to the current address plus 1.
- R5: Opcode 1100 branches when `src_data` differs from the immediate, and opcode 1110 branches when they are equal. Neither writes a register.
- R6: Opcode 1101 branches when `src_data` AND the immediate is nonzero, and opcode 1111 branches when it is zero. Neither writes a register.
- R7: Opcode 1011 always branches and pushes the current address plus 1 onto the return stack, which holds up to 4 entries. A call made while the stack is full does not push, still branches, and sets `stk_overflow`. `stk_overflow` stays set until reset.
- R8: An ALU instruction with bit 24 set still requests its register write. The next address is then the most recently pushed entry, which is removed from the stack. If the stack is empty, the next address is the current one plus 1 and `stk_underflow` is set, and it stays set until reset.
- R9: An accepted instruction with opcode 0110 or 0111, or with any of bits 31..29 set, requests no write. From the next cycle, `illegal` is 1, `instr_ready` is 0 and `fetch_addr` is frozen until reset.
- R10: In a cycle without a transfer, `dst_we` is 0, and `fetch_addr` and the stack are unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present |
| instr_ready | output | 1 | Unit accepts instructions (low once halted) |
| instr | input | 32 | Instruction fetched from `fetch_addr` |
| carry_in | input | 1 | Carry flag from the ALU |
| src_data | input | 8 | Value of the register named by bits 15..8 |
| fetch_addr | output | 9 | Program counter, address of the next instruction |
| dst_we | output | 1 | Register write requested this cycle |
| dst_to_index | output | 1 | The write goes to the fixed index register |
| dst_addr | output | 8 | Destination register address for ALU writes |
| illegal | output | 1 | Sticky: reserved instruction accepted, sequencer halted |
| stk_overflow | output | 1 | Sticky: call made with a full return stack |
| stk_underflow | output | 1 | Sticky: return made with an empty return stack |

## Verification
The bench builds the unit with its default 9-bit program counter and four-entry return stack. This lets a short program reach the wrap from address 511 to 0. It also lets five nested calls overfill the stack, and the matching returns then run it dry and cause an underflow. Source data is driven either as the compare immediate or as a pseudo-random byte. Carry and instruction validity are also pseudo-random. As a result, every conditional branch is observed both taken and not taken, and stalls fall between transfers. A separate reset phase exercises halting on nonzero high bits.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 8;
  localparam int TGT_W   = 9;

  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_JUMP = 2'd1,
    CLS_CMP  = 2'd2,
    CLS_BAD  = 2'd3
  } op_class_e;

  localparam logic [3:0] OP_JMP  = 4'b1000;
  localparam logic [3:0] OP_JC   = 4'b1001;
  localparam logic [3:0] OP_JNC  = 4'b1010;
  localparam logic [3:0] OP_CALL = 4'b1011;
  localparam logic [3:0] OP_JNE  = 4'b1100;
  localparam logic [3:0] OP_JNZ  = 4'b1101;
  localparam logic [3:0] OP_JE   = 4'b1110;
  localparam logic [3:0] OP_JZ   = 4'b1111;

  typedef struct packed {
    op_class_e        cls;
    logic [3:0]       op;
    logic             ret;
    logic [TGT_W-1:0] tgt;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] imm;
    logic             side_wr;
  } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [2:0] hi_bits;

  always_comb begin
    hi_bits     = instr[31:29];
    dec.op      = instr[28:25];
    dec.ret     = instr[24];
    dec.tgt     = instr[24:16];
    dec.dst     = instr[23:16];
    dec.src     = instr[15:8];
    dec.imm     = instr[7:0];
    dec.side_wr = (instr[15:8] != '0) || (instr[7:0] != '0);
    if (hi_bits != 3'b000) begin
      dec.cls = CLS_BAD;
    end else begin
      unique casez (instr[28:25])
        4'b00??, 4'b010?: dec.cls = CLS_ALU;
        4'b011?:          dec.cls = CLS_BAD;
        4'b10??:          dec.cls = CLS_JUMP;
        default:          dec.cls = CLS_CMP;
      endcase
    end
  end
endmodule

// File: rtl/seq_cond.sv
module seq_cond
  import seq_pkg::*;
(
  input  dec_t             dec,
  input  logic             carry_in,
  input  logic [REG_W-1:0] src_data,
  output logic             take
);
  logic eq_hit;
  logic mask_zero;

  always_comb begin
    eq_hit    = (src_data == dec.imm);
    mask_zero = ((src_data & dec.imm) == '0);
    take      = 1'b0;
    if (dec.cls == CLS_JUMP || dec.cls == CLS_CMP) begin
      case (dec.op)
        OP_JMP:  take = 1'b1;
        OP_CALL: take = 1'b1;
        OP_JC:   take = carry_in;
        OP_JNC:  take = !carry_in;
        OP_JNE:  take = !eq_hit;
        OP_JE:   take = eq_hit;
        OP_JNZ:  take = !mask_zero;
        OP_JZ:   take = mask_zero;
        default: take = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/seq_rstack.sv
module seq_rstack #(
  parameter int DEPTH = 4,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] slots [DEPTH];
  logic [CW-1:0] count;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign wr_idx = IW'(count);
  assign rd_idx = IW'(count - CW'(1));
  assign top    = empty ? '0 : slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CW'(1);
    end else if (pop && !empty) begin
      count <= count - CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (push && !full && wr_idx == IW'(g)) begin
        slots[g] <= push_val;
      end
    end
  end
endmodule

// File: rtl/seq_branch_unit.sv
module seq_branch_unit
  import seq_pkg::*;
#(
  parameter int STK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  input  logic               carry_in,
  input  logic [REG_W-1:0]   src_data,
  output logic [TGT_W-1:0]   fetch_addr,
  output logic               dst_we,
  output logic               dst_to_index,
  output logic [REG_W-1:0]   dst_addr,
  output logic               illegal,
  output logic               stk_overflow,
  output logic               stk_underflow
);
  dec_t             dec;
  logic             take;
  logic             fire;
  logic             is_bad;
  logic             push_req;
  logic             pop_req;
  logic [TGT_W-1:0] pc_q;
  logic [TGT_W-1:0] pc_inc;
  logic [TGT_W-1:0] pc_nxt;
  logic [TGT_W-1:0] stk_top;
  logic             stk_empty;
  logic             stk_full;
  logic             halt_q;
  logic             ovf_q;
  logic             unf_q;

  seq_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  seq_cond u_cond (
    .dec      (dec),
    .carry_in (carry_in),
    .src_data (src_data),
    .take     (take)
  );

  seq_rstack #(
    .DEPTH (STK_DEPTH),
    .AW    (TGT_W)
  ) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_req),
    .pop      (pop_req),
    .push_val (pc_inc),
    .top      (stk_top),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  assign instr_ready = !halt_q;
  assign fire        = instr_valid && !halt_q;
  assign is_bad      = (dec.cls == CLS_BAD);
  assign pc_inc      = pc_q + TGT_W'(1);
  assign push_req    = fire && (dec.cls == CLS_JUMP) && (dec.op == OP_CALL);
  assign pop_req     = fire && (dec.cls == CLS_ALU) && dec.ret;

  always_comb begin
    pc_nxt = pc_q;
    if (fire && !is_bad) begin
      if ((dec.cls == CLS_JUMP || dec.cls == CLS_CMP) && take) begin
        pc_nxt = dec.tgt;
      end else if (pop_req && !stk_empty) begin
        pc_nxt = stk_top;
      end else begin
        pc_nxt = pc_inc;
      end
    end
  end

  always_comb begin
    dst_we       = 1'b0;
    dst_to_index = 1'b0;
    dst_addr     = '0;
    if (fire) begin
      if (dec.cls == CLS_ALU) begin
        dst_we   = 1'b1;
        dst_addr = dec.dst;
      end else if (dec.cls == CLS_JUMP && dec.side_wr) begin
        dst_we       = 1'b1;
        dst_to_index = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (fire && is_bad) halt_q <= 1'b1;
      if (push_req && stk_full) ovf_q <= 1'b1;
      if (pop_req && stk_empty) unf_q <= 1'b1;
    end
  end

  assign fetch_addr    = pc_q;
  assign illegal       = halt_q;
  assign stk_overflow  = ovf_q;
  assign stk_underflow = unf_q;
endmodule

// File: rtl/seq_branch_unit_chk.sv
module seq_branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        instr_ready,
  input logic [31:0] instr,
  input logic [8:0]  fetch_addr,
  input logic        dst_we,
  input logic        illegal,
  input logic        stk_overflow,
  input logic        stk_underflow
);
  logic xfer;
  assign xfer = instr_valid && instr_ready;

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (illegal && !instr_ready));

  // R9
  reserved_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && instr[31:29] == 3'b000 && instr[28:26] == 3'b011) |=> illegal);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> !dst_we);

  // R10
  idle_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(fetch_addr));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_overflow |=> stk_overflow);

  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_underflow |=> stk_underflow);

  // R2
  alu_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && instr[31:29] == 3'b000 && (instr[28:27] == 2'b00 || instr[28:26] == 3'b010) && !instr[24])
      |=> fetch_addr == $past(fetch_addr) + 9'd1);

  // R4
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && instr[31:25] == 7'b0001000) |=> fetch_addr == $past(instr[24:16]));
endmodule

bind seq_branch_unit seq_branch_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .instr         (instr),
  .fetch_addr    (fetch_addr),
  .dst_we        (dst_we),
  .illegal       (illegal),
  .stk_overflow  (stk_overflow),
  .stk_underflow (stk_underflow)
);

// File: tb/seq_branch_unit_bench.sv
module seq_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_ready;
  logic [31:0] instr;
  logic        carry_in;
  logic [7:0]  src_data;
  logic [8:0]  fetch_addr;
  logic        dst_we;
  logic        dst_to_index;
  logic [7:0]  dst_addr;
  logic        illegal;
  logic        stk_overflow;
  logic        stk_underflow;

  always #2.5 clk = !clk;

  seq_branch_unit u_seq_branch_unit (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_ready (instr_ready),
    .instr (instr), .carry_in (carry_in), .src_data (src_data), .fetch_addr (fetch_addr),
    .dst_we (dst_we), .dst_to_index (dst_to_index), .dst_addr (dst_addr), .illegal (illegal),
    .stk_overflow (stk_overflow), .stk_underflow (stk_underflow)
  );

  logic [31:0] mem [512];
  int  n_checks = 0;
  int  n_fail   = 0;
  int  m_pc;
  int  m_stk[$];
  bit  m_ill, m_ovf, m_unf;
  int  rng = 32'h1234_5678;
  int  cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  function automatic logic [31:0] f_alu(input int op, input bit ret, input int dst, input int src, input int imm);
    return {3'b000, 4'(op), ret, 8'(dst), 8'(src), 8'(imm)};
  endfunction

  function automatic logic [31:0] f_br(input int op, input int tgt, input int src, input int imm);
    return {3'b000, 4'(op), 9'(tgt), 8'(src), 8'(imm)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (pc=%0d)", tag, act, exp, m_pc);
    end
  endtask

  function automatic int next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; carry_in = 1'b0; src_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 0; m_stk.delete(); m_ill = 0; m_ovf = 0; m_unf = 0;
    chk(fetch_addr == 0, "R1 fetch_addr", fetch_addr, 0);
    chk(instr_ready == 1'b1, "R1 instr_ready", instr_ready, 1);
    chk({illegal, stk_overflow, stk_underflow} == 3'b000, "R1 flags",
        {illegal, stk_overflow, stk_underflow}, 0);
  endtask

  task automatic step(input bit vld);
    int  op, src, imm, tgt, r;
    bit  bad, take, e_we, e_idx;
    int  e_addr;
    chk(fetch_addr == 9'(m_pc), "R2/R4/R8 fetch_addr", fetch_addr, m_pc);
    chk(illegal == m_ill, "R9 illegal", illegal, m_ill);
    chk(instr_ready == !m_ill, "R9 instr_ready", instr_ready, !m_ill);
    chk(stk_overflow == m_ovf, "R7 stk_overflow", stk_overflow, m_ovf);
    chk(stk_underflow == m_unf, "R8 stk_underflow", stk_underflow, m_unf);
    r = next_rand();
    instr_valid = vld;
    carry_in    = r[9];
    src_data    = r[3] ? 8'h3C : 8'(r >>> 11);
    instr       = mem[m_pc];
    #1;
    op  = instr[28:25]; tgt = instr[24:16]; src = instr[15:8]; imm = instr[7:0];
    bad = (instr[31:29] != 0) || op == 6 || op == 7;
    e_we = 0; e_idx = 0; e_addr = 0;
    if (vld && !m_ill && !bad) begin
      if (op <= 5) begin
        e_we = 1; e_addr = instr[23:16];
      end else if (op <= 11 && (src != 0 || imm != 0)) begin
        e_we = 1; e_idx = 1;
      end
    end
    chk(dst_we == e_we, "R3/R5/R6/R10 dst_we", dst_we, e_we);
    chk(dst_to_index == e_idx, "R3 dst_to_index", dst_to_index, e_idx);
    chk(dst_addr == 8'(e_addr), "R2 dst_addr", dst_addr, e_addr);
    if (vld && !m_ill) begin
      if (bad) begin
        m_ill = 1;
      end else if (op <= 5) begin
        if (instr[24]) begin
          if (m_stk.size() == 0) begin m_unf = 1; m_pc = (m_pc + 1) % 512; end
          else m_pc = m_stk.pop_back();
        end else m_pc = (m_pc + 1) % 512;
      end else begin
        case (op)
          8, 11:   take = 1;
          9:       take = carry_in;
          10:      take = !carry_in;
          12:      take = (src_data != 8'(imm));
          14:      take = (src_data == 8'(imm));
          13:      take = ((src_data & 8'(imm)) != 0);
          default: take = ((src_data & 8'(imm)) == 0);
        endcase
        if (op == 11) begin
          if (m_stk.size() < 4) m_stk.push_back((m_pc + 1) % 512);
          else m_ovf = 1;
        end
        m_pc = take ? tgt : (m_pc + 1) % 512;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    // Phase 1: main flow, conditions, calls and wrap (R2-R6, R10)
    for (int i = 0; i < 512; i++) mem[i] = f_alu(i % 6, 0, i, 1, 0);
    mem[0]   = f_alu(0, 0, 8'h10, 1, 3);
    mem[1]   = f_alu(5, 0, 8'h11, 2, 0);
    mem[2]   = f_br(8, 5, 0, 0);
    mem[5]   = f_br(8, 7, 2, 9);
    mem[7]   = f_br(9, 10, 0, 4);
    mem[9]   = f_br(10, 12, 0, 0);
    mem[10]  = f_alu(0, 0, 20, 0, 1);
    mem[11]  = f_br(10, 12, 3, 0);
    mem[12]  = f_br(12, 14, 5, 8'h3C);
    mem[14]  = f_br(14, 16, 5, 8'h3C);
    mem[16]  = f_br(13, 18, 6, 8'h81);
    mem[18]  = f_br(15, 20, 6, 8'h81);
    mem[20]  = f_br(11, 40, 0, 0);
    mem[21]  = f_br(11, 45, 7, 0);
    mem[22]  = f_br(8, 511, 0, 0);
    mem[40]  = f_alu(2, 1, 30, 1, 1);
    mem[45]  = f_alu(3, 1, 31, 1, 1);
    mem[511] = f_alu(4, 0, 32, 0, 0);
    do_reset();
    for (int c = 0; c < 600; c++) step((next_rand() & 3) != 0);

    // Phase 2: stack overflow, underflow and reserved opcode (R7, R8, R9)
    for (int i = 0; i < 512; i++) mem[i] = f_alu(1, 0, 1, 0, 0);
    mem[0]  = f_br(11, 10, 0, 0);
    mem[10] = f_br(11, 20, 0, 0);
    mem[20] = f_br(11, 30, 0, 0);
    mem[30] = f_br(11, 40, 0, 0);
    mem[40] = f_br(11, 50, 0, 0);
    mem[50] = f_alu(0, 1, 2, 0, 0);
    mem[31] = f_alu(0, 1, 3, 0, 0);
    mem[21] = f_alu(0, 1, 4, 0, 0);
    mem[11] = f_alu(0, 1, 5, 0, 0);
    mem[1]  = f_alu(0, 1, 6, 0, 0);
    mem[2]  = f_br(8, 60, 0, 0);
    mem[60] = f_alu(6, 0, 7, 0, 0);
    do_reset();
    for (int c = 0; c < 60; c++) step((next_rand() & 7) != 0);
    chk(stk_overflow && stk_underflow, "R7/R8 both flags set", {stk_overflow, stk_underflow}, 3);
    chk(illegal && fetch_addr == 9'd60, "R9 halted at 60", fetch_addr, 60);

    // Phase 3: nonzero high bits are illegal (R9)
    mem[0] = 32'h2000_0000 | f_alu(0, 0, 9, 0, 0);
    do_reset();
    for (int c = 0; c < 10; c++) step(1'b1);
    chk(illegal && fetch_addr == 9'd0, "R9 high bits halt", fetch_addr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule